// File: doc/BRIEF.md
# Serial ADC Readout Sequencer

This block runs a single-channel successive-approximation converter from one system clock. Once every sample period it pulls the conversion-start line low and waits a programmable number of system clocks for the conversion to finish. It then drops chip select and drives a serial clock while it shifts the result in, most significant bit first. At the end of a full frame it presents the word on a parallel bus together with a one-cycle valid strobe.

The first frame after reset is a converter reset and carries no result. In the early-deselect variant, chip select goes high after a few bits while the serial clock keeps running to the end of the frame. In the short-clock variant, chip select stays low for the whole frame but only a few serial clock pulses are issued. The period length, the conversion wait, the frame length, the serial clock divide, the conversion-start low width and the number of bits in the reset frame are all parameters. An elaboration-time budget check drives a constant overrun flag.

The state machine has four states. `ST_IDLE` is the reset state and the gap between frames. `ST_CONV` is the conversion wait. `ST_SHIFT` is the chip-select-low readout. `ST_TAIL` is the clock-only tail of an early-deselect reset frame. The transitions are as follows:
- IDLE→CONV when the period counter wraps.
- CONV→SHIFT when the wait count expires.
- SHIFT→IDLE at the end of the last bit.
- SHIFT→TAIL in the reset frame of the early-deselect variant, once the reset-frame bits are done.
- TAIL→IDLE at the end of the last bit.

Top module: `adc_frame_seq`

## Requirements
- R1: While `rst_n` is low, `cs_n_o` and `cnv_n_o` are 1 and `sclk_o` is 0.
- R2: After reset is released, `cnv_n_o` falls on the first clock edge, while `cs_n_o` is still 1 and before `sclk_o` has ever been high.
- R3: `cnv_n_o` stays low for exactly `CNV_LOW_CLKS` cycles, then stays high until the next sample period starts.
- R4: Successive falling edges of `cnv_n_o` are exactly `PERIOD_CLKS` cycles apart.
- R5: `cs_n_o` falls exactly `CONV_WAIT_CLKS` cycles after `cnv_n_o` falls.
- R6: In a normal frame, `cs_n_o` is low for `FRAME_BITS*SCLK_DIV` cycles. Each bit lasts `SCLK_DIV` cycles, with `sclk_o` low in the first half and high in the second half. There are exactly `FRAME_BITS` rising edges while `cs_n_o` is low.
- R7: With `RESET_MODE = RST_EARLY_CS`, the first frame holds `cs_n_o` low for only `RST_BITS*SCLK_DIV` cycles. `sclk_o` keeps toggling until the period has seen `FRAME_BITS` rising edges in total.
- R8: With `RESET_MODE = RST_SHORT_CLK`, the first frame holds `cs_n_o` low for a full frame, but only `RST_BITS` rising edges of `sclk_o` occur.
- R9: The reset frame never asserts `valid_o`.
- R10: Each normal frame asserts `valid_o` for exactly one cycle, in the cycle in which `cs_n_o` returns high. In that cycle `result_o` holds the `FRAME_BITS` bits read on the rising `sclk_o` edges, with the first bit read placed in the most significant position.
- R11: `overrun_o` is 1 exactly when `CONV_WAIT_CLKS + FRAME_BITS*SCLK_DIV + CS_HIGH_CLKS` exceeds `PERIOD_CLKS`.
- R12: `sclk_o` is high while `cs_n_o` is high only during the tail of an early-deselect reset frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data from the converter |
| cnv_n_o | output | 1 | Conversion start, active low |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | FRAME_BITS | Last complete conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| overrun_o | output | 1 | Constant flag: timing budget exceeds the period |

## Verification
The assertions assume a legal parameter set:
- `SCLK_DIV` is even and at least 2.
- `RST_BITS` is below `FRAME_BITS`.
- `CNV_LOW_CLKS` does not exceed the wait.
- The frame fits inside the period.

They also assume that the converter changes `sdata_i` only after a falling serial clock edge, or when chip select falls, and holds it steady across each rising edge. The stimulus model in the bench updates the data line half a system clock after it sees such an edge, so every sampled bit has a full half-period of setup. Only the two instances that meet the budget are checked against timing. The over-budget instance is examined only at its overrun flag.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } seq_state_e;

    typedef enum logic {
        RST_EARLY_CS  = 1'b0,
        RST_SHORT_CLK = 1'b1
    } rst_mode_e;

endpackage

// File: rtl/adc_seq_period.sv
module adc_seq_period #(
    parameter int PERIOD_CLKS = 55
) (
    input  logic clk,
    input  logic rst_n,
    output logic start_o
);
    localparam int CW = (PERIOD_CLKS > 2) ? $clog2(PERIOD_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PERIOD_CLKS - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign start_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_bitclk.sv
module adc_seq_bitclk #(
    parameter int SCLK_DIV   = 2,
    parameter int FRAME_BITS = 12,
    parameter int BIT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic             sclk_hi_o,
    output logic             rise_o,
    output logic             bit_end_o,
    output logic [BIT_W-1:0] bit_idx_o
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int PW   = $clog2(SCLK_DIV);

    logic [PW-1:0]    ph_q;
    logic [BIT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            idx_q <= '0;
        end else if (!run_i) begin
            ph_q  <= '0;
            idx_q <= '0;
        end else if (bit_end_o) begin
            ph_q  <= '0;
            idx_q <= idx_q + 1'b1;
        end else begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    assign rise_o    = run_i && (ph_q == PW'(HALF - 1));
    assign bit_end_o = run_i && (ph_q == PW'(SCLK_DIV - 1));
    assign bit_idx_o = idx_q;

    generate
        if (SCLK_DIV == 2) begin : g_div2
            assign sclk_hi_o = ph_q[0];
        end else begin : g_divn
            assign sclk_hi_o = (ph_q >= PW'(HALF));
        end
    endgenerate

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter #(
    parameter int FRAME_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_i,
    input  logic                  sdata_i,
    output logic [FRAME_BITS-1:0] word_o
);
    logic [FRAME_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= {sh_q[FRAME_BITS-2:0], sdata_i};
        end
    end

    assign word_o = sh_q;

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int        PERIOD_CLKS    = 55,
    parameter int        CONV_WAIT_CLKS = 27,
    parameter int        FRAME_BITS     = 12,
    parameter int        SCLK_DIV       = 2,
    parameter int        CNV_LOW_CLKS   = 8,
    parameter int        CS_HIGH_CLKS   = 2,
    parameter int        RST_BITS       = 7,
    parameter rst_mode_e RESET_MODE     = RST_EARLY_CS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sdata_i,
    output logic                  cnv_n_o,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic [FRAME_BITS-1:0] result_o,
    output logic                  valid_o,
    output logic                  overrun_o
);
    localparam int BIT_W   = $clog2(FRAME_BITS + 1);
    localparam int WW      = $clog2(CONV_WAIT_CLKS + 1);
    localparam int BUDGET  = CONV_WAIT_CLKS + FRAME_BITS * SCLK_DIV + CS_HIGH_CLKS;
    localparam bit OVERRUN = (BUDGET > PERIOD_CLKS);
    localparam bit EARLY   = (RESET_MODE == RST_EARLY_CS);

    seq_state_e       state_q, state_d;
    logic [WW-1:0]    wcnt_q;
    logic             first_q;
    logic             start;
    logic             sclk_hi, rise, bit_end;
    logic [BIT_W-1:0] bit_idx;
    logic             run, frame_done, gate;
    logic [FRAME_BITS-1:0] word;
    logic             valid_q;
    logic [FRAME_BITS-1:0] result_q;

    adc_seq_period #(.PERIOD_CLKS(PERIOD_CLKS)) period_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_o (start)
    );

    adc_seq_bitclk #(
        .SCLK_DIV   (SCLK_DIV),
        .FRAME_BITS (FRAME_BITS),
        .BIT_W      (BIT_W)
    ) bitclk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .sclk_hi_o (sclk_hi),
        .rise_o    (rise),
        .bit_end_o (bit_end),
        .bit_idx_o (bit_idx)
    );

    adc_seq_shifter #(.FRAME_BITS(FRAME_BITS)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (state_q == ST_SHIFT && rise),
        .sdata_i (sdata_i),
        .word_o  (word)
    );

    assign run = (state_q == ST_SHIFT) || (state_q == ST_TAIL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CONV;
            ST_CONV:  if (wcnt_q == WW'(CONV_WAIT_CLKS - 1)) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (bit_end) begin
                    if (first_q && EARLY && bit_idx == BIT_W'(RST_BITS - 1)) begin
                        state_d = ST_TAIL;
                    end else if (bit_idx == BIT_W'(FRAME_BITS - 1)) begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_TAIL:  if (bit_end && bit_idx == BIT_W'(FRAME_BITS - 1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign frame_done = run && (state_d == ST_IDLE);
    assign gate       = first_q && !EARLY && (bit_idx >= BIT_W'(RST_BITS));

    // Output decode
    always_comb begin
        cnv_n_o = 1'b1;
        cs_n_o  = 1'b1;
        sclk_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CONV:  cnv_n_o = !(wcnt_q < WW'(CNV_LOW_CLKS));
            ST_SHIFT: begin
                cs_n_o = 1'b0;
                sclk_o = sclk_hi && !gate;
            end
            ST_TAIL:  sclk_o = sclk_hi;
            default:  ;
        endcase
    end

    // Wait counter, reset-frame flag and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q   <= '0;
            first_q  <= 1'b1;
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            wcnt_q  <= (state_q == ST_CONV) ? wcnt_q + 1'b1 : '0;
            valid_q <= frame_done && !first_q;
            if (frame_done && !first_q) begin
                result_q <= word;
            end
            if (frame_done) begin
                first_q <= 1'b0;
            end
        end
    end

    assign valid_o   = valid_q;
    assign result_o  = result_q;
    assign overrun_o = OVERRUN;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int CONV_WAIT_CLKS = 27
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_n,
    input logic cs_n,
    input logic sclk,
    input logic valid,
    input logic first
);
    int   since_cnv;
    logic cnv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q     <= 1'b1;
            since_cnv <= 0;
        end else begin
            cnv_q <= cnv_n;
            if (cnv_q && !cnv_n) begin
                since_cnv <= 1;
            end else if (since_cnv < 1000000) begin
                since_cnv <= since_cnv + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_idle_in_reset: assert (cs_n && cnv_n && !sclk)
                else $error("R1: outputs not idle in reset");
        end
    end

    a_r2_cnv_falls_alone: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n) |-> (cs_n && !sclk));

    a_r5_cs_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (since_cnv == CONV_WAIT_CLKS));

    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r10_valid_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    a_r12_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !first) |-> !cs_n);

endmodule

bind adc_frame_seq adc_seq_chk #(.CONV_WAIT_CLKS(CONV_WAIT_CLKS)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnv_n (cnv_n_o),
    .cs_n  (cs_n_o),
    .sclk  (sclk_o),
    .valid (valid_o),
    .first (first_q)
);

// File: tb/adc_frame_seq_tb_lane.sv
module adc_frame_seq_tb_lane #(
    parameter int          PERIOD = 55,
    parameter int          WAIT   = 27,
    parameter int          BITS   = 12,
    parameter int          DIV    = 2,
    parameter int          CNVL   = 8,
    parameter int          RB     = 7,
    parameter bit          SHORT  = 1'b0,
    parameter int unsigned SEED   = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnv_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            valid,
    input  logic [BITS-1:0] result,
    output logic            sdata,
    output int              n_chk,
    output int              n_fail,
    output int              frames
);
    int cyc, t_cnv, t_cs, t_rise, rises_cs, rises_per, valids_per, idx;
    logic pcnv, pcs, psclk, pvalid;
    bit act_seen;
    logic [BITS-1:0] word;
    int unsigned seed_q = SEED;

    initial begin
        n_chk  = 0;
        n_fail = 0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (lane short=%0d frame %0d): actual %0d expected %0d",
                     tag, SHORT, frames, act, exp);
        end
    endtask

    function automatic int exp_low_len(bit first);
        return first ? (SHORT ? BITS * DIV : RB * DIV) : BITS * DIV;
    endfunction

    function automatic int exp_cs_rises(bit first);
        return first ? RB : BITS;
    endfunction

    function automatic int exp_per_rises(bit first);
        return (first && SHORT) ? RB : BITS;
    endfunction

    function automatic logic [BITS-1:0] alt_word(bit hi_first);
        logic [BITS-1:0] w;
        for (int b = 0; b < BITS; b++) w[b] = hi_first ? b[0] : !b[0];
        return w;
    endfunction

    function automatic logic [BITS-1:0] pick_word(int f);
        logic [BITS-1:0] w;
        unique case (f)
            2:       w = '0;
            3:       w = '1;
            4:       w = alt_word(1'b1);
            5:       w = alt_word(1'b0);
            default: begin
                w = BITS'($urandom(seed_q));
                seed_q = seed_q * 32'd1103515245 + 32'd12345;
            end
        endcase
        return w;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; frames = 0; act_seen = 0; idx = BITS;
            rises_cs = 0; rises_per = 0; valids_per = 0;
            t_cnv = 0; t_cs = 0; t_rise = 0; word = '0;
            sdata = 1'b0;
        end else begin
            cyc++;
            if (frames == 0 && (!cs_n || sclk)) act_seen = 1;
            if (pcnv && !cnv_n) begin
                if (frames == 0) begin
                    chk(!act_seen && cs_n, "R2 cnv first", int'(act_seen), 0);
                end else begin
                    chk(cyc - t_cnv == PERIOD, "R4 period", cyc - t_cnv, PERIOD);
                    chk(rises_per == exp_per_rises(frames == 1),
                        frames == 1 ? (SHORT ? "R8 reset rises" : "R7 reset rises") : "R6 rises",
                        rises_per, exp_per_rises(frames == 1));
                    if (frames == 1) chk(valids_per == 0, "R9 reset valid", valids_per, 0);
                    else             chk(valids_per == 1, "R10 valid count", valids_per, 1);
                end
                frames++;
                t_cnv = cyc; rises_per = 0; valids_per = 0;
            end
            if (!pcnv && cnv_n) chk(cyc - t_cnv == CNVL, "R3 cnv width", cyc - t_cnv, CNVL);
            if (pcs && !cs_n) begin
                chk(cyc - t_cnv == WAIT, "R5 wait", cyc - t_cnv, WAIT);
                t_cs = cyc; rises_cs = 0; idx = 0;
                word = pick_word(frames);
            end
            if (!psclk && sclk) begin
                rises_per++;
                if (!cs_n) begin
                    rises_cs++;
                    if (rises_cs == 1) chk(cyc - t_cs == DIV / 2, "R6 first rise", cyc - t_cs, DIV / 2);
                    else               chk(cyc - t_rise == DIV, "R6 bit spacing", cyc - t_rise, DIV);
                    t_rise = cyc;
                end else begin
                    chk(frames == 1 && !SHORT, "R12 sclk while deselected", 1, 0);
                end
            end
            if (psclk && !sclk && !cs_n) idx++;
            if (!pcs && cs_n) begin
                chk(cyc - t_cs == exp_low_len(frames == 1),
                    frames == 1 ? (SHORT ? "R8 cs low" : "R7 cs low") : "R6 cs low",
                    cyc - t_cs, exp_low_len(frames == 1));
                chk(rises_cs == exp_cs_rises(frames == 1),
                    frames == 1 ? "R7/R8 rises selected" : "R6 rises selected",
                    rises_cs, exp_cs_rises(frames == 1));
            end
            if (valid) begin
                valids_per++;
                chk(frames != 1, "R9 valid in reset frame", 1, 0);
                chk(!pcs && cs_n, "R10 valid with deselect", int'(cs_n), 1);
                chk(result == word, "R10 result", int'(result), int'(word));
                if (pvalid) chk(1'b0, "R10 valid width", 2, 1);
            end
            sdata = (!cs_n && idx < BITS) ? word[BITS-1-idx] : 1'b0;
        end
        pcnv = cnv_n; pcs = cs_n; psclk = sclk; pvalid = valid;
    end

endmodule

// File: tb/adc_frame_seq_tb_top.sv
module adc_frame_seq_tb_top;
    import adc_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BITS       = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic sd_a, cnv_a, cs_a, sck_a, val_a, ovr_a;
    logic sd_b, cnv_b, cs_b, sck_b, val_b, ovr_b;
    logic cnv_c, cs_c, sck_c, val_c, ovr_c;
    logic [BITS-1:0] res_a, res_b, res_c;
    int chk_a, fail_a, fr_a, chk_b, fail_b, fr_b;
    int n_chk = 0;
    int n_fail = 0;

    adc_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sdata_i(sd_a), .cnv_n_o(cnv_a), .cs_n_o(cs_a),
        .sclk_o(sck_a), .result_o(res_a), .valid_o(val_a), .overrun_o(ovr_a));

    adc_frame_seq #(.PERIOD_CLKS(110), .SCLK_DIV(4), .RST_BITS(5),
                    .RESET_MODE(RST_SHORT_CLK)) dut_short_i (
        .clk(clk), .rst_n(rst_n), .sdata_i(sd_b), .cnv_n_o(cnv_b), .cs_n_o(cs_b),
        .sclk_o(sck_b), .result_o(res_b), .valid_o(val_b), .overrun_o(ovr_b));

    adc_frame_seq #(.PERIOD_CLKS(40)) dut_ovr_i (
        .clk(clk), .rst_n(rst_n), .sdata_i(1'b0), .cnv_n_o(cnv_c), .cs_n_o(cs_c),
        .sclk_o(sck_c), .result_o(res_c), .valid_o(val_c), .overrun_o(ovr_c));

    adc_frame_seq_tb_lane #(.PERIOD(55), .DIV(2), .RB(7), .SHORT(1'b0), .SEED(11)) lane_a (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_a), .cs_n(cs_a), .sclk(sck_a), .valid(val_a),
        .result(res_a), .sdata(sd_a), .n_chk(chk_a), .n_fail(fail_a), .frames(fr_a));

    adc_frame_seq_tb_lane #(.PERIOD(110), .DIV(4), .RB(5), .SHORT(1'b1), .SEED(29)) lane_b (
        .clk(clk), .rst_n(rst_n), .cnv_n(cnv_b), .cs_n(cs_b), .sclk(sck_b), .valid(val_b),
        .result(res_b), .sdata(sd_b), .n_chk(chk_b), .n_fail(fail_b), .frames(fr_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_idle();
        chk(cs_a && cnv_a && !sck_a, "R1 idle in reset (dut_i)", {cs_a, cnv_a, sck_a}, 3'b110);
        chk(cs_b && cnv_b && !sck_b, "R1 idle in reset (dut_short_i)", {cs_b, cnv_b, sck_b}, 3'b110);
        chk(cs_c && cnv_c && !sck_c, "R1 idle in reset (dut_ovr_i)", {cs_c, cnv_c, sck_c}, 3'b110);
    endtask

    task automatic run_until(input int want, inout bit hung);
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (fr_a >= want && fr_b >= want) return;
        end
        hung = 1'b1;
    endtask

    initial begin
        bit hung = 1'b0;
        repeat (4) @(negedge clk);
        check_idle();
        chk(ovr_a == 1'b0, "R11 budget fits (dut_i)", int'(ovr_a), 0);
        chk(ovr_b == 1'b0, "R11 budget fits (dut_short_i)", int'(ovr_b), 0);
        chk(ovr_c == 1'b1, "R11 budget exceeded (dut_ovr_i)", int'(ovr_c), 1);
        rst_n = 1'b1;
        run_until(14, hung);
        // mid-run reset: outputs return idle, then the reset frame repeats
        @(negedge clk);
        #(CLK_PERIOD / 4) rst_n = 1'b0;
        @(negedge clk);
        check_idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        if (!hung) run_until(16, hung);
        if (hung) chk(1'b0, "watchdog", 0, 1);
        n_chk  += chk_a + chk_b;
        n_fail += fail_a + fail_b;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule